// File: doc/BRIEF.md
# General-Purpose Pin Bank with Change Interrupts

This block is a bank of general-purpose pins arranged as a parameterised number of equal register groups (three groups of eight by default, 24 pins in all). Each group holds a direction register, an output latch, an interrupt-enable register and a sticky change-flag register. Software picks, pin by pin, whether the pad is driven or sampled. A data write lands only in the bits whose direction is output. A data read returns the latch for output pins and the synchronised pad level for input pins.

Every input passes through a two-stage synchroniser. A level change in either direction on an input pin whose enable bit is set marks that pin's flag. Flags stay set until software reads the flag register of their group, and that read clears only that group. If an edge is detected in the same cycle as the read, its flag stays set, so the event is not lost. A single interrupt line is high while any flag in any group is set.

The register port is a plain strobe interface. The address is a register kind plus a group index. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), every output latch bit and every flag is zero, and `irq` is low.
- R2: `addr[3:2]` selects the register kind: 0 = direction, 1 = data, 2 = interrupt enable, 3 = flag. `addr[1:0]` selects group g, and bit i of that group maps to pin 8g+i. Group index 3 has no registers: a read there returns 0 and a write there changes nothing.
- R3: A direction bit of 1 makes the pin an output, and `pin_oe` mirrors the direction registers. The direction registers read back as written.
- R4: A data write updates only the latch bits whose direction bit is 1. `pin_out` always shows the latch.
- R5: A data read returns the latch bit for output pins and the synchronised pad level for input pins. `rdata` is valid on the cycle after `rd_en`.
- R6: A pad change is seen through two synchroniser flops. The flag, and so `irq`, is set at the third rising clock edge after the change and not before.
- R7: An input pin with its enable bit set raises its flag on a rising level change and also on a falling one.
- R8: A change on a pin that is an output, or whose enable bit is clear, raises no flag.
- R9: Reading a group's flag register returns its flags and clears that group. Other groups are not affected.
- R10: If an edge on an enabled input pin is detected in the same cycle as a read of its group's flags, that flag is set after the read, and the read returns the flags that were set before it.
- R11: `irq` is high exactly while at least one flag bit in any group is set.
- R12: A flag stays set, without further pin activity, until its group's flag register is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register kind (bits 3:2) and group index (bits 1:0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pad levels, asynchronous |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Output enable per pin, 1 = drive |
| irq | output | 1 | Shared change interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are never raised together and that pad levels are zero while reset is asserted, so the synchroniser and the edge history agree when reset is released. The stimulus drives the strobes one at a time on falling clock edges and changes pad levels only after reset, between register accesses. Each pad change is followed by enough idle cycles for the synchroniser to settle before a flag is read. The one exception is the deliberate same-cycle edge-and-read case, which is placed on the exact edge where the flag is set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      KIND_DIR  = 2'd0,
      KIND_DATA = 2'd1,
      KIND_IEN  = 2'd2,
      KIND_FLAG = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 24,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= async_in;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_group.sv
module gpio_group #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_data,
   input  logic             wr_ien,
   input  logic             rd_flag,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] ien_q,
   output logic [WIDTH-1:0] flag_q,
   output logic [WIDTH-1:0] data_rd
);
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_group: WIDTH must be positive");
   end

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] edge_w;
   logic [WIDTH-1:0] set_w;

   assign edge_w  = pin_sync ^ prev_q;
   assign set_w   = edge_w & ien_q & ~dir_q;
   assign data_rd = (out_q & dir_q) | (pin_sync & ~dir_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         ien_q  <= '0;
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= pin_sync;
         if (wr_dir)  dir_q <= wdata;
         if (wr_ien)  ien_q <= wdata;
         if (wr_data) out_q <= (wdata & dir_q) | (out_q & ~dir_q);
         flag_q <= (rd_flag ? '0 : flag_q) | set_w;
      end
   end

   // R8
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q)) & ~$past(edge_w & ien_q & ~dir_q)) == '0);

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_flag |=> (flag_q & ~$past(set_w)) == '0);

   // R12
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_flag |=> ($past(flag_q) & ~flag_q) == '0);

   // R4
   data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0);

   // R10
   race_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flag && set_w != '0) |=> (flag_q & $past(set_w)) == $past(set_w));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int NUM_GROUPS  = 3,
   parameter int GROUP_W     = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NPIN   = NUM_GROUPS * GROUP_W,
   localparam int GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int ADDR_W = gpio_pkg::KIND_W + GSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [GROUP_W-1:0] wdata,
   output logic [GROUP_W-1:0] rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              irq
);
   import gpio_pkg::*;

   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("gpio_bank: NUM_GROUPS must be positive");
   end

   reg_kind_e          kind;
   logic [GSEL_W-1:0]  gsel;
   logic [NPIN-1:0]    pin_sync;
   logic [NPIN-1:0]    flag_all;
   logic [GROUP_W-1:0] rd_val;
   logic [GROUP_W-1:0] dir_a  [NUM_GROUPS];
   logic [GROUP_W-1:0] out_a  [NUM_GROUPS];
   logic [GROUP_W-1:0] ien_a  [NUM_GROUPS];
   logic [GROUP_W-1:0] flag_a [NUM_GROUPS];
   logic [GROUP_W-1:0] data_a [NUM_GROUPS];

   assign kind = reg_kind_e'(addr[ADDR_W-1 -: KIND_W]);
   assign gsel = addr[GSEL_W-1:0];

   gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit;
      assign hit = (gsel == GSEL_W'(g));

      gpio_group #(.WIDTH(GROUP_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_dir   (wr_en && hit && kind == KIND_DIR),
         .wr_data  (wr_en && hit && kind == KIND_DATA),
         .wr_ien   (wr_en && hit && kind == KIND_IEN),
         .rd_flag  (rd_en && hit && kind == KIND_FLAG),
         .wdata    (wdata),
         .pin_sync (pin_sync[g*GROUP_W +: GROUP_W]),
         .dir_q    (dir_a[g]),
         .out_q    (out_a[g]),
         .ien_q    (ien_a[g]),
         .flag_q   (flag_a[g]),
         .data_rd  (data_a[g])
      );

      assign pin_out [g*GROUP_W +: GROUP_W] = out_a[g];
      assign pin_oe  [g*GROUP_W +: GROUP_W] = dir_a[g];
      assign flag_all[g*GROUP_W +: GROUP_W] = flag_a[g];
   end

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (gsel == GSEL_W'(g)) begin
            unique case (kind)
               KIND_DIR:  rd_val = dir_a[g];
               KIND_DATA: rd_val = data_a[g];
               KIND_IEN:  rd_val = ien_a[g];
               KIND_FLAG: rd_val = flag_a[g];
               default:   rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   assign irq = |flag_all;

   // R6
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(pin_in != pin_sync, 2));

   // R1
   oe_after_reset_chk: assert property (@(posedge clk)
      !rst_n |=> pin_oe == '0);
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [23:0] pin_in = '0;
   logic [23:0] pin_out;
   logic [23:0] pin_oe;
   logic        irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // op: 0 write, 1 read and compare, 2 set pads and settle
   // fields: {op[1:0], addr[3:0], data[23:0], exp[7:0], req[3:0]}
   localparam int NV = 22;
   localparam logic [41:0] VEC [NV] = '{
      {2'd0, 4'h0, 24'h00000F, 8'h00, 4'd3},  // R3 dir group0
      {2'd1, 4'h0, 24'h000000, 8'h0F, 4'd3},  // R3 read back
      {2'd0, 4'h4, 24'h0000FF, 8'h00, 4'd4},  // R4 data write
      {2'd1, 4'h4, 24'h000000, 8'h0F, 4'd5},  // R5 latch only on outputs
      {2'd2, 4'h0, 24'h000030, 8'h00, 4'd5},
      {2'd1, 4'h4, 24'h000000, 8'h3F, 4'd5},  // R5 pads on inputs
      {2'd0, 4'h8, 24'h0000FF, 8'h00, 4'd8},
      {2'd1, 4'hC, 24'h000000, 8'h00, 4'd8},  // R8 earlier edge not enabled
      {2'd2, 4'h0, 24'h000010, 8'h00, 4'd7},
      {2'd1, 4'hC, 24'h000000, 8'h20, 4'd7},  // R7 falling
      {2'd1, 4'hC, 24'h000000, 8'h00, 4'd9},  // R9 cleared by read
      {2'd2, 4'h0, 24'h000011, 8'h00, 4'd8},
      {2'd1, 4'hC, 24'h000000, 8'h00, 4'd8},  // R8 output pin ignored
      {2'd0, 4'h1, 24'h000000, 8'h00, 4'd2},
      {2'd0, 4'h9, 24'h000081, 8'h00, 4'd2},
      {2'd2, 4'h0, 24'h008111, 8'h00, 4'd7},
      {2'd1, 4'hD, 24'h000000, 8'h81, 4'd7},  // R7 rising, R2 group1
      {2'd1, 4'hC, 24'h000000, 8'h00, 4'd2},  // R2 group0 untouched
      {2'd0, 4'hA, 24'h000002, 8'h00, 4'd2},
      {2'd2, 4'h0, 24'h028111, 8'h00, 4'd2},
      {2'd1, 4'hE, 24'h000000, 8'h02, 4'd2},  // R2 pin17 is group2 bit1
      {2'd1, 4'h9, 24'h000000, 8'h81, 4'd2}   // R2 enable read back
   };

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check(tag, {16'h0, rdata}, {16'h0, exp});
   endtask

   task automatic pads(input logic [23:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", pin_oe, 24'h0);
      check("R1 pin_out", pin_out, 24'h0);
      check("R1 irq", {23'h0, irq}, 24'h0);
      rd_chk("R1 flag0", 4'hC, 8'h00);
      rd_chk("R1 dir1", 4'h1, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [3:0]  a;
         logic [23:0] d;
         logic [7:0]  e;
         logic [3:0]  rq;
         {op, a, d, e, rq} = VEC[i];
         case (op)
            2'd0: wr(a, d[7:0]);
            2'd1: rd_chk($sformatf("R%0d table step %0d", rq, i), a, e);
            default: pads(d);
         endcase
      end

      // R2 unused group index
      wr(4'h3, 8'hFF);
      rd_chk("R2 group3 read", 4'h3, 8'h00);
      check("R2 group3 write ignored", pin_oe, 24'h00000F);

      // R4 data write masked by direction, R3 oe follows direction
      wr(4'h4, 8'hA5);
      wr(4'h0, 8'hFF);
      check("R4 latch masked", {16'h0, pin_out[7:0]}, 24'h05);
      check("R3 oe group0", {16'h0, pin_oe[7:0]}, 24'hFF);
      pads(24'h028101);
      rd_chk("R8 pin now output", 4'hC, 8'h00);

      // R12 sticky, R11 shared line
      @(negedge clk);
      pin_in = 24'h028001;
      repeat (20) @(negedge clk);
      check("R11 irq set", {23'h0, irq}, 24'h1);
      rd_chk("R12 flag kept", 4'hD, 8'h01);
      check("R11 irq clear", {23'h0, irq}, 24'h0);

      // R10 edge in the read cycle
      pads(24'h028101);
      @(negedge clk);
      pin_in = 24'h020101;
      @(negedge clk);
      @(negedge clk);
      rd_en = 1'b1; addr = 4'hD;
      @(negedge clk);
      rd_en = 1'b0;
      check("R10 read old flags", {16'h0, rdata}, 24'h01);
      check("R10 irq kept", {23'h0, irq}, 24'h1);
      rd_chk("R10 new flag kept", 4'hD, 8'h80);

      // R6 synchroniser latency
      @(negedge clk);
      pin_in = 24'h000101;
      @(negedge clk);
      check("R6 after one edge", {23'h0, irq}, 24'h0);
      @(negedge clk);
      check("R6 after two edges", {23'h0, irq}, 24'h0);
      @(negedge clk);
      check("R6 after three edges", {23'h0, irq}, 24'h1);
      rd_chk("R6 flag2", 4'hE, 8'h02);
      check("R9 all clear", {23'h0, irq}, 24'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule